// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM Core

This block is the storage and data path that sits behind an access controller. It is a word-addressed array whose words are split into byte lanes. Each lane carries eight data bits and one parity bit. Every clock edge may sample one access from the controller: an address, a select, a sleep request, the write strobes and the write data. A write lands in the array at the same edge, and only the chosen lanes are changed. A read fills a two-stage pipeline: the address register and then the output data register.

The output side takes the place of a bidirectional pad. It is a plain data-out bus plus a drive-enable flag and its complement, a high-impedance flag. The drive enable follows the output-enable input and the sleep input without waiting for a clock. It drops for one cycle after any selected write, so the bus can turn around. Data written on one edge can be read back by the very next access, with no stale lanes.

Top module: `pipelined_bytewrite_sram`

## Requirements
- R1: With `gw_n` low on a selected, non-sleeping edge, all lanes of the addressed word are written from `din`, whatever `bwe_n` and `lane_we_n` hold.
- R2: With `gw_n` high and `bwe_n` low, every lane whose `lane_we_n` bit is low is written and every other lane keeps its contents. Lane i is data bits [8i+7:8i] plus parity bit 32+i (lane 0 = bits 7:0 and bit 32, lane 1 = bits 15:8 and bit 33, and so on).
- R3: With `gw_n` high and either `bwe_n` high or all `lane_we_n` bits high, the selected edge is a read and the array is left unchanged.
- R4: A read sampled at edge k puts the addressed word on `dout`, with `dout_en` high, after edge k+1 and not before.
- R5: After an edge that samples a selected write, `dout_en` is low for that cycle, whatever `oe_n` is.
- R6: A read sampled on the edge right after a write to the same address returns the newly written lanes merged with the lanes that were kept.
- R7: `oe_n` high forces `dout_en` low at once, with no clock edge needed. Releasing it restores the pending output.
- R8: An edge with `sel` low writes nothing and starts no read, so `dout_en` is low after the following edge. Data from a read started just before it still appears.
- R9: `sleep` high forces `dout_en` low at once, and any access sampled while `sleep` is high is ignored. The array contents are kept.
- R10: After reset, `dout_en` is low and no read is pending.
- R11: `dout_hiz` is always the complement of `dout_en`, and `dout` is zero whenever `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the pipeline registers |
| sel | input | 1 | Access select for this edge |
| sleep | input | 1 | Power-down request: blocks accesses and output drive |
| addr | input | ADDR_W | Word address |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| din | input | LANES*(LANE_BITS+1) | Write data, parity bits in the top LANES bits |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | LANES*(LANE_BITS+1) | Read data, zero when not driven |
| dout_en | output | 1 | Output driver enable |
| dout_hiz | output | 1 | High-impedance indication |

## Verification
Inputs change on the falling edge and are sampled by the next rising edge. Read data is due one full cycle later, so the bench checks `dout` at the second falling edge after the read is driven. It also checks at the first falling edge that the enable is still low. The bus-turnaround and deselect checks look at the falling edge right after the edge that sampled the write or the deselect. The oe_n and sleep checks change the input mid-cycle and look two nanoseconds later, with no clock edge in between. A model array inside the bench merges lanes according to R1 to R3 and gives the expected word for every read.

// File: rtl/pipelined_bytewrite_sram.sv
module pipelined_bytewrite_sram #(
  parameter int ADDR_W    = 8,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               sel,
  input  logic                               sleep,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic                               gw_n,
  input  logic                               bwe_n,
  input  logic [LANES-1:0]                   lane_we_n,
  input  logic [LANES*(LANE_BITS+1)-1:0]     din,
  input  logic                               oe_n,
  output logic [LANES*(LANE_BITS+1)-1:0]     dout,
  output logic                               dout_en,
  output logic                               dout_hiz
);

  localparam int DATA_BITS = LANES * LANE_BITS;
  localparam int DW        = DATA_BITS + LANES;
  localparam int DEPTH     = 1 << ADDR_W;

  logic [DW-1:0]     mem [DEPTH];
  logic [LANES-1:0]  lane_wr;
  logic [DW-1:0]     wmask;
  logic              access, do_wr, do_rd;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_pend, wr_seen, out_valid;
  logic [DW-1:0]     data_q;

  assign lane_wr = !gw_n  ? {LANES{1'b1}} :
                   !bwe_n ? ~lane_we_n    : {LANES{1'b0}};
  assign access  = sel & ~sleep;
  assign do_wr   = access & (|lane_wr);
  assign do_rd   = access & ~(|lane_wr);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wmask[i*LANE_BITS +: LANE_BITS] = {LANE_BITS{lane_wr[i]}};
    assign wmask[DATA_BITS + i]            = lane_wr[i];
  end

  always_ff @(posedge clk) begin
    if (do_wr)
      mem[addr] <= (mem[addr] & ~wmask) | (din & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      rd_pend   <= 1'b0;
      wr_seen   <= 1'b0;
      out_valid <= 1'b0;
      data_q    <= '0;
    end else begin
      rd_pend   <= do_rd;
      wr_seen   <= do_wr;
      out_valid <= rd_pend;
      if (do_rd)   addr_q <= addr;
      if (rd_pend) data_q <= mem[addr_q];
    end
  end

  assign dout_en  = out_valid & ~wr_seen & ~oe_n & ~sleep;
  assign dout_hiz = ~dout_en;
  assign dout     = dout_en ? data_q : '0;

  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    do_wr |=> !dout_en);

  p_oe_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  p_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ##1 !dout_en);

  p_sleep_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en);

  p_zero_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0) && dout_hiz);

endmodule

// File: tb/pipelined_bytewrite_sram_test.sv
module pipelined_bytewrite_sram_test;
  logic        clk = 0, rst_n = 0, sel = 0, sleep = 0;
  logic [7:0]  addr = 0;
  logic        gw_n = 1, bwe_n = 1, oe_n = 0;
  logic [3:0]  lane_we_n = 4'hF;
  logic [35:0] din = 0;
  logic [35:0] dout;
  logic        dout_en, dout_hiz;
  logic [35:0] model [256];
  int checks = 0, fails = 0;

  pipelined_bytewrite_sram uut (.*);

  always #10 clk = ~clk;

  function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] d,
                                        logic g, logic b, logic [3:0] l);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++)
      if (!g || (!b && !l[i])) begin
        r[i*8 +: 8] = d[i*8 +: 8];
        r[32+i]     = d[32+i];
      end
    return r;
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(logic s, logic [7:0] a, logic g, logic b, logic [3:0] l, logic [35:0] d);
    sel = s; addr = a; gw_n = g; bwe_n = b; lane_we_n = l; din = d;
    if (s && !sleep) model[a] = merge(model[a], d, g, b, l);
  endtask

  task automatic idle(); put(0, 0, 1, 1, 4'hF, 0); endtask
  task automatic rd(logic [7:0] a); put(1, a, 1, 1, 4'hF, 0); endtask

  task automatic rd_expect(logic [7:0] a, string tag);
    rd(a); tick(); idle(); tick();
    chk({tag, " en"}, {35'd0, dout_en}, 36'd1);
    chk({tag, " data"}, dout, model[a]);
  endtask

  task automatic t_reset();
    chk("R10 en after reset", {35'd0, dout_en}, 36'd0);
    chk("R11 hiz after reset", {35'd0, dout_hiz}, 36'd1);
    chk("R11 dout zero", dout, 36'd0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < 100; a++) begin
      put(1, 8'(a), 0, 1, 4'hF, {4'(a), 32'(a) * 32'h0101_0101} ^ 36'h5_A5A5_A5A5);
      tick();
    end
    idle(); tick();
  endtask

  task automatic t_global();
    put(1, 10, 0, 1, 4'hF, 36'h9_1234_5678); tick();
    put(1, 11, 0, 0, 4'b1010, 36'h6_CAFE_BEEF); tick();
    idle(); tick();
    rd_expect(10, "R1 global write");
    chk("R1 full word", dout, 36'h9_1234_5678);
    rd_expect(11, "R1 gw overrides lanes");
    chk("R1 all lanes", dout, 36'h6_CAFE_BEEF);
  endtask

  task automatic t_bytes();
    put(1, 20, 0, 1, 4'hF, 36'h0); tick();
    put(1, 20, 1, 0, 4'b1101, 36'hF_FFFF_FFFF); tick();
    idle(); tick();
    rd_expect(20, "R2 lane1");
    chk("R2 lane1 map", dout, 36'h2_0000_FF00);
    put(1, 20, 1, 0, 4'b0011, 36'hF_FFFF_FFFF); tick();
    idle(); tick();
    rd_expect(20, "R2 lanes2,3");
    chk("R2 lanes2,3 map", dout, 36'hE_FFFF_FF00);
  endtask

  task automatic t_read_kinds();
    put(1, 20, 1, 1, 4'h0, 36'h1_1111_1111); tick(); idle(); tick();
    chk("R3 bwe high is read", dout, 36'hE_FFFF_FF00);
    put(1, 20, 1, 0, 4'hF, 36'h1_1111_1111); tick(); idle(); tick();
    chk("R3 no lanes is read", dout, 36'hE_FFFF_FF00);
    rd_expect(20, "R3 array unchanged");
  endtask

  task automatic t_latency();
    rd(30); tick();
    chk("R4 not yet valid", {35'd0, dout_en}, 36'd0);
    idle(); tick();
    chk("R4 valid", dout, model[30]);
    for (int a = 40; a < 44; a++) begin
      rd(8'(a)); tick();
      if (a > 40) chk("R4 stream", dout, model[a-1]);
    end
    idle(); tick();
    chk("R4 stream last", dout, model[43]);
    tick();
    chk("R8 empty after stream", {35'd0, dout_en}, 36'd0);
  endtask

  task automatic t_turn();
    rd(50); tick();
    put(1, 51, 0, 1, 4'hF, 36'h3_3333_3333); tick();
    chk("R5 write forces hiz", {35'd0, dout_en}, 36'd0);
    chk("R11 hiz flag", {35'd0, dout_hiz}, 36'd1);
    idle(); tick();
    rd_expect(51, "R5 write landed");
  endtask

  task automatic t_pass();
    put(1, 60, 1, 0, 4'b1110, 36'h1_0000_00AB); tick();
    rd(60); tick(); idle(); tick();
    chk("R6 byte pass-through", dout, model[60]);
    put(1, 60, 0, 1, 4'hF, 36'h7_0F0F_0F0F); tick();
    rd(60); tick(); idle(); tick();
    chk("R6 full pass-through", dout, 36'h7_0F0F_0F0F);
  endtask

  task automatic t_oe();
    rd(70); tick(); idle(); tick();
    oe_n = 1; #2;
    chk("R7 oe high hiz", {35'd0, dout_en}, 36'd0);
    chk("R11 dout zero oe", dout, 36'd0);
    oe_n = 0; #2;
    chk("R7 oe restored", dout, model[70]);
    tick();
  endtask

  task automatic t_desel();
    put(0, 80, 0, 0, 4'h0, 36'h1_2345_6789); tick();
    idle(); tick();
    chk("R8 deselected no output", {35'd0, dout_en}, 36'd0);
    rd_expect(80, "R8 deselected no write");
    rd(80); tick();
    put(0, 81, 1, 1, 4'hF, 0); tick();
    chk("R8 prior read still out", dout, model[80]);
    tick();
    chk("R8 off after deselect", {35'd0, dout_en}, 36'd0);
  endtask

  task automatic t_sleep();
    sleep = 1;
    put(1, 90, 0, 1, 4'hF, 36'h8_8888_8888); tick();
    rd(91); tick();
    sleep = 0; idle(); tick();
    chk("R9 read in sleep ignored", {35'd0, dout_en}, 36'd0);
    rd_expect(90, "R9 write in sleep ignored");
    rd(90); tick(); idle(); tick();
    sleep = 1; #2;
    chk("R9 sleep hiz", {35'd0, dout_en}, 36'd0);
    sleep = 0; #2;
    chk("R9 wake output", dout, model[90]);
    tick();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    tick(); tick();
    t_reset();
    rst_n = 1; tick();
    t_fill();
    t_global();
    t_bytes();
    t_read_kinds();
    t_latency();
    t_turn();
    t_pass();
    t_oe();
    t_desel();
    t_sleep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule